// File: doc/BRIEF.md
# Critical Word First Refill Controller

This block runs the refill of a single cache line after a miss. The line holds eight data words. Memory returns the line in four beats, and each beat carries two words. The controller decides the order in which beats are requested and writes each returned beat into the line buffer. As soon as the beat holding the missed word lands, it releases the stalled core, so the core does not wait for the whole line. The remaining beats keep filling in the background. The line is marked valid only once every beat has been written.

Two fill modes are sampled when a miss is accepted. In sequential mode, beats are requested from beat 0 upward, and the core is released when the beat holding the missed word comes back. In critical-first mode, the first beat requested is the one holding the missed word, and the order then wraps around the line. In that mode the core is released after a single transfer. Tag lookup and victim choice happen outside this block.

Top module: `refill_cwf_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it rises, `miss_ready_o`=1 and `mem_req_valid_o`, `line_we_o`, `restart_o`, `fill_done_o` and `line_valid_o` are all 0.
- R2: With `mode_cwf_i`=0 at acceptance, beats are requested in the order 0,1,2,3, whatever the missed word is.
- R3: With `mode_cwf_i`=1 at acceptance, beats are requested in the order c, c+1, c+2, c+3 modulo 4, where c = `miss_word_i` / 2.
- R4: `restart_o` is a single-cycle pulse, given exactly once per fill. It comes in the cycle after the response that carries beat c. In that cycle `restart_data_o` holds the missed word, which is bits [32*(w%2)+31 : 32*(w%2)] of that beat's data.
- R5: The restart follows the first response in critical-first mode, and follows response number c+1 in sequential mode.
- R6: Each accepted response produces a one-cycle `line_we_o` in the next cycle. That pulse carries the requested beat index on `line_beat_o` and the response data on `line_data_o`, with word 2b+i of beat b in bits [32i+31:32i].
- R7: `fill_done_o` pulses for one cycle together with the fourth line write. `line_valid_o` rises in that same cycle, stays high until the next miss is accepted, and is low from the cycle after an acceptance. `line_tag_o` holds the tag taken at acceptance.
- R8: `miss_ready_o` is low from the cycle after acceptance until the cycle that `fill_done_o` is high. A miss presented during a fill has no effect on the beat order or on `line_tag_o`.
- R9: A change of `mode_cwf_i` during a fill does not change the order of that fill.
- R10: A request that has not been accepted keeps `mem_req_valid_o` high and `mem_req_beat_o` unchanged. After acceptance it drops until the response arrives.
- R11: A response that arrives while no request is outstanding is ignored: no line write and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request |
| miss_ready_o | output | 1 | Controller idle, miss accepted on valid |
| miss_tag_i | input | 20 | Tag of the missing line |
| miss_word_i | input | 3 | Offset of the missed word in the line |
| mode_cwf_i | input | 1 | 1 = critical-first order, 0 = sequential |
| mem_req_valid_o | output | 1 | Beat read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_beat_o | output | 2 | Requested beat index |
| mem_rsp_valid_i | input | 1 | Beat data returned |
| mem_rsp_data_i | input | 64 | Beat data, lower word first |
| line_we_o | output | 1 | Line buffer beat write |
| line_beat_o | output | 2 | Beat index written |
| line_data_o | output | 64 | Beat data written |
| line_valid_o | output | 1 | Line completely filled |
| line_tag_o | output | 20 | Tag of the line being filled |
| restart_o | output | 1 | Missed word available, core may resume |
| restart_data_o | output | 32 | The missed word |
| fill_done_o | output | 1 | Last beat written |

## Verification
Every result registered from a response, meaning the line write, the restart pulse, the done pulse and the valid rise, falls due one cycle after the cycle in which the response is driven. The bench drives each response on a falling edge and checks these outputs on the next falling edge. A request becomes visible in the cycle after acceptance or after the previous response. It drops in the cycle after the memory's ready, and the bench checks both of those cycles along with every cycle of request hold and response latency. The bench also records the transfer position of the single restart in each fill, so that release after one transfer or after c+1 transfers is checked directly.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/refill_order.sv
module refill_order #(
  parameter int unsigned BEATS  = 4,
  localparam int unsigned BIDX_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BIDX_W-1:0] start_i,
  input  logic              cwf_i,
  input  logic              step_i,
  output logic [BIDX_W-1:0] beat_o,
  output logic              last_o
);
  logic [BIDX_W-1:0] base_q, cnt_q;
  logic              cwf_q;
  logic [BIDX_W:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      cwf_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= start_i;
      cnt_q  <= '0;
      cwf_q  <= cwf_i;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // wrap offset walk around the line
  always_comb begin
    sum = {1'b0, base_q} + {1'b0, cnt_q};
    if (sum >= (BIDX_W+1)'(BEATS)) sum = sum - (BIDX_W+1)'(BEATS);
  end

  assign beat_o = cwf_q ? sum[BIDX_W-1:0] : cnt_q;
  assign last_o = (cnt_q == BIDX_W'(BEATS-1));
endmodule

// File: rtl/refill_fsm.sv
module refill_fsm
  import refill_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic miss_valid_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic last_i,
  output logic miss_ready_o,
  output logic load_o,
  output logic req_valid_o,
  output logic take_o
);
  fill_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_valid_i) state_d = ST_REQ;
      ST_REQ:  if (req_ready_i)  state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i)  state_d = last_i ? ST_IDLE : ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  assign miss_ready_o = (state_q == ST_IDLE);
  assign load_o       = miss_ready_o && miss_valid_i;
  assign req_valid_o  = (state_q == ST_REQ);
  assign take_o       = (state_q == ST_WAIT) && rsp_valid_i;
endmodule

// File: rtl/refill_capture.sv
module refill_capture #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WPB    = 2,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned TAG_W  = 20,
  localparam int unsigned BIDX_W = $clog2(BEATS),
  localparam int unsigned SUB_W  = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int unsigned BEAT_W = WORD_W * WPB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [BIDX_W-1:0] crit_beat_i,
  input  logic [SUB_W-1:0]  crit_sub_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [BIDX_W-1:0] beat_i,
  input  logic [BEAT_W-1:0] data_i,
  output logic              line_we_o,
  output logic [BIDX_W-1:0] line_beat_o,
  output logic [BEAT_W-1:0] line_data_o,
  output logic              line_valid_o,
  output logic [TAG_W-1:0]  line_tag_o,
  output logic              restart_o,
  output logic [WORD_W-1:0] restart_data_o,
  output logic              fill_done_o
);
  logic [BIDX_W-1:0] crit_beat_q;
  logic [SUB_W-1:0]  crit_sub_q;
  logic [WORD_W-1:0] words [WPB];

  for (genvar i = 0; i < WPB; i++) begin : g_split
    assign words[i] = data_i[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_beat_q <= '0;
      crit_sub_q  <= '0;
      line_tag_o  <= '0;
    end else if (load_i) begin
      crit_beat_q <= crit_beat_i;
      crit_sub_q  <= crit_sub_i;
      line_tag_o  <= tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_we_o      <= 1'b0;
      line_beat_o    <= '0;
      line_data_o    <= '0;
      restart_o      <= 1'b0;
      restart_data_o <= '0;
      fill_done_o    <= 1'b0;
      line_valid_o   <= 1'b0;
    end else begin
      line_we_o   <= take_i;
      restart_o   <= take_i && (beat_i == crit_beat_q);
      fill_done_o <= take_i && last_i;
      if (take_i) begin
        line_beat_o <= beat_i;
        line_data_o <= data_i;
        if (beat_i == crit_beat_q) restart_data_o <= words[crit_sub_q];
      end
      if (load_i)                line_valid_o <= 1'b0;
      else if (take_i && last_i) line_valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/refill_cwf_ctrl.sv
module refill_cwf_ctrl #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WPB    = 2,
  parameter int unsigned TAG_W  = 20,
  localparam int unsigned BEATS  = WORDS / WPB,
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned BIDX_W = $clog2(BEATS),
  localparam int unsigned SUB_W  = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int unsigned BEAT_W = WORD_W * WPB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [TAG_W-1:0]  miss_tag_i,
  input  logic [OFF_W-1:0]  miss_word_i,
  input  logic              mode_cwf_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [BIDX_W-1:0] mem_req_beat_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BEAT_W-1:0] mem_rsp_data_i,
  output logic              line_we_o,
  output logic [BIDX_W-1:0] line_beat_o,
  output logic [BEAT_W-1:0] line_data_o,
  output logic              line_valid_o,
  output logic [TAG_W-1:0]  line_tag_o,
  output logic              restart_o,
  output logic [WORD_W-1:0] restart_data_o,
  output logic              fill_done_o
);
  logic              load, take, last;
  logic [BIDX_W-1:0] beat, crit_beat;
  logic [SUB_W-1:0]  crit_sub;

  assign crit_beat = BIDX_W'(miss_word_i / OFF_W'(WPB));
  assign crit_sub  = SUB_W'(miss_word_i % OFF_W'(WPB));

  refill_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_valid_i(miss_valid_i),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .last_i      (last),
    .miss_ready_o(miss_ready_o),
    .load_o      (load),
    .req_valid_o (mem_req_valid_o),
    .take_o      (take)
  );

  refill_order #(.BEATS(BEATS)) u_order (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .start_i(crit_beat),
    .cwf_i  (mode_cwf_i),
    .step_i (take),
    .beat_o (beat),
    .last_o (last)
  );

  assign mem_req_beat_o = beat;

  refill_capture #(
    .WORD_W(WORD_W), .WPB(WPB), .BEATS(BEATS), .TAG_W(TAG_W)
  ) u_cap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .tag_i         (miss_tag_i),
    .crit_beat_i   (crit_beat),
    .crit_sub_i    (crit_sub),
    .take_i        (take),
    .last_i        (last),
    .beat_i        (beat),
    .data_i        (mem_rsp_data_i),
    .line_we_o     (line_we_o),
    .line_beat_o   (line_beat_o),
    .line_data_o   (line_data_o),
    .line_valid_o  (line_valid_o),
    .line_tag_o    (line_tag_o),
    .restart_o     (restart_o),
    .restart_data_o(restart_data_o),
    .fill_done_o   (fill_done_o)
  );
endmodule

// File: rtl/refill_cwf_ctrl_chk.sv
module refill_cwf_ctrl_chk #(
  parameter int unsigned BIDX_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [BIDX_W-1:0] mem_req_beat_o,
  input logic              line_we_o,
  input logic              line_valid_o,
  input logic              restart_o,
  input logic              fill_done_o
);
  logic restarted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         restarted_q <= 1'b0;
    else if (miss_valid_i && miss_ready_o) restarted_q <= 1'b0;
    else if (restart_o)                  restarted_q <= 1'b1;
  end

  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);                                           // R4
  AST_RESTART_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !restarted_q);                                         // R4
  AST_RESTART_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> line_we_o);                                            // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |=> !fill_done_o);                                       // R7
  AST_DONE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> (line_we_o && line_valid_o));                        // R7
  AST_VALID_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_valid_o) |-> fill_done_o);                                // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !miss_ready_o);                                  // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_beat_o))); // R10
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);          // R10
endmodule

bind refill_cwf_ctrl refill_cwf_ctrl_chk #(.BIDX_W(BIDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .miss_valid_i   (miss_valid_i),
  .miss_ready_o   (miss_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_beat_o (mem_req_beat_o),
  .line_we_o      (line_we_o),
  .line_valid_o   (line_valid_o),
  .restart_o      (restart_o),
  .fill_done_o    (fill_done_o)
);

// File: tb/refill_cwf_ctrl_test.sv
`timescale 1ns/1ps
module refill_cwf_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic        miss_ready_o;
  logic [19:0] miss_tag_i = '0;
  logic [2:0]  miss_word_i = '0;
  logic        mode_cwf_i = 1'b0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [1:0]  mem_req_beat_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        line_we_o;
  logic [1:0]  line_beat_o;
  logic [63:0] line_data_o;
  logic        line_valid_o;
  logic [19:0] line_tag_o;
  logic        restart_o;
  logic [31:0] restart_data_o;
  logic        fill_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  refill_cwf_ctrl uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wv(input logic [19:0] t, input int w);
    return {t, 9'd0, 3'(w)};
  endfunction

  task automatic run_fill(input int word, input bit cwf, input logic [19:0] tag,
                          input int rdy_dly, input int lat, input bit disturb);
    int crit;
    int rst_pos;
    crit = word / 2;
    rst_pos = -1;
    @(negedge clk_i);
    chk(miss_ready_o == 1'b1, "R8", "ready before miss", miss_ready_o, 1);
    miss_valid_i = 1'b1; miss_tag_i = tag; miss_word_i = 3'(word); mode_cwf_i = cwf;
    @(negedge clk_i);
    miss_valid_i = 1'b0;
    chk(miss_ready_o == 1'b0, "R8", "ready during fill", miss_ready_o, 0);
    chk(line_valid_o == 1'b0, "R7", "valid cleared on accept", line_valid_o, 0);
    if (disturb) begin
      miss_valid_i = 1'b1; miss_tag_i = ~tag; miss_word_i = 3'(word + 3);
      mode_cwf_i = ~cwf;
    end
    for (int k = 0; k < 4; k++) begin
      int eb;
      eb = cwf ? (crit + k) % 4 : k;
      for (int d = 0; d < rdy_dly; d++) begin
        chk(mem_req_valid_o && mem_req_beat_o == 2'(eb), "R10", "request held",
            mem_req_beat_o, eb);
        @(negedge clk_i);
      end
      chk(mem_req_valid_o == 1'b1, cwf ? "R3" : "R2", "request valid", mem_req_valid_o, 1);
      chk(mem_req_beat_o == 2'(eb), cwf ? "R3" : "R2", "beat order", mem_req_beat_o, eb);
      mem_req_ready_i = 1'b1;
      @(negedge clk_i);
      mem_req_ready_i = 1'b0;
      chk(mem_req_valid_o == 1'b0, "R10", "request drops", mem_req_valid_o, 0);
      for (int d = 0; d < lat; d++) begin
        chk(!line_we_o && !restart_o, "R6", "no write while waiting", line_we_o, 0);
        @(negedge clk_i);
      end
      if (k == 3 && disturb) begin
        miss_valid_i = 1'b0;
        mode_cwf_i = cwf;
      end
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i = {wv(tag, 2*eb+1), wv(tag, 2*eb)};
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      chk(line_we_o == 1'b1, "R6", "line write", line_we_o, 1);
      chk(line_beat_o == 2'(eb), "R6", "line beat", line_beat_o, eb);
      chk(line_data_o == {wv(tag, 2*eb+1), wv(tag, 2*eb)}, "R6", "line data",
          line_data_o, {wv(tag, 2*eb+1), wv(tag, 2*eb)});
      chk(restart_o == (eb == crit), "R4", "restart on critical beat", restart_o, eb == crit);
      if (restart_o) begin
        rst_pos = k;
        chk(restart_data_o == wv(tag, word), "R4", "restart word", restart_data_o, wv(tag, word));
      end
      chk(fill_done_o == (k == 3), "R7", "done pulse", fill_done_o, k == 3);
      chk(line_valid_o == (k == 3), "R7", "line valid", line_valid_o, k == 3);
    end
    chk(rst_pos == (cwf ? 0 : crit), "R5", "restart transfer index", rst_pos, cwf ? 0 : crit);
    chk(miss_ready_o == 1'b1, "R8", "ready at done", miss_ready_o, 1);
    chk(line_tag_o == tag, "R7", "line tag", line_tag_o, tag);
    @(negedge clk_i);
    chk(!fill_done_o && !restart_o && !line_we_o, "R7", "pulses end", fill_done_o, 0);
    chk(line_valid_o == 1'b1, "R7", "valid holds", line_valid_o, 1);
    if (disturb)
      chk(line_tag_o == tag, "R9", "tag and order unaffected by busy miss", line_tag_o, tag);
  endtask

  task automatic stray_rsp();
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    chk(!line_we_o && !restart_o, "R11", "stray response ignored", line_we_o, 0);
    chk(!mem_req_valid_o && miss_ready_o, "R11", "stays idle", mem_req_valid_o, 0);
  endtask

  task automatic reset_test();
    #1;
    chk(miss_ready_o && !mem_req_valid_o && !line_we_o && !restart_o
        && !fill_done_o && !line_valid_o, "R1", "outputs in reset", 0, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(miss_ready_o && !mem_req_valid_o && !line_we_o && !restart_o
        && !fill_done_o && !line_valid_o, "R1", "outputs after reset", 0, 0);
  endtask

  initial begin
    reset_test();
    stray_rsp();
    run_fill(2, 1'b0, 20'h1A2B3, 0, 0, 1'b0);
    run_fill(7, 1'b0, 20'h00F00, 2, 1, 1'b0);
    run_fill(0, 1'b0, 20'h55555, 0, 3, 1'b0);
    run_fill(2, 1'b1, 20'hABCDE, 0, 0, 1'b0);
    run_fill(5, 1'b1, 20'h12345, 1, 2, 1'b0);
    run_fill(7, 1'b1, 20'hFEDCB, 3, 0, 1'b0);
    run_fill(0, 1'b1, 20'h0A0A0, 0, 1, 1'b0);
    run_fill(3, 1'b1, 20'h77777, 1, 1, 1'b1);
    run_fill(6, 1'b0, 20'h33333, 0, 2, 1'b1);
    stray_rsp();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule